// File: doc/BRIEF.md
# Package Idle-State Resolver

This block merges the low-power idle requests of every hardware thread in a small multi-core processor model. The first step gives one resolved state per core. The second step gives one resolved state for the whole package. Each thread presents an encoded idle request, which comes from a halt or wait-hint event. The platform supplies a single permission level that allows the package to enter a low-power state.

Each core resolves to the shallowest state that any of its threads requests. The package resolves to the shallowest state among its cores. The package goes below the running state only while the platform grants permission. A configuration input decides whether the extended-halt level is honoured or folded down to plain halt.

The block decides and reports states only. It drives no clock gating, power gating or voltage control. A one-cycle pulse marks every change of the package state.

Top module: `idle_state_resolver`

## Requirements
- R1: State codes are 3 bits, and a larger value is a deeper state: 0 run, 1 halt, 2 extended halt, 3 sleep, 4 off. A thread code of 5, 6 or 7 is illegal and counts as run (0). The package output never exceeds 4.
- R2: Each core state is the shallowest normalised request among that core's threads. It is registered and appears one clock after the requests are sampled. A thread requesting run therefore keeps its core in run.
- R3: While `c1e_en_i` is low, a thread request of 2 (extended halt) counts as 1 (halt). No core then reports state 2.
- R4: The package state is registered from the core states one clock later. When permission is high and the shallowest core state is 2 or deeper, the package state equals that shallowest core state. Otherwise the package state is 0.
- R5: If any core is in run (0) or halt (1), the package is in run on the next clock.
- R6: If `perm_i` is low, the package is in run on the next clock, whatever the core states are. No hysteresis delays this return.
- R7: The package reaches sleep (3) only when the shallowest core is in sleep, every other core is in sleep or off, and permission is high. The package reaches off (4) only when every core is off and permission is high.
- R8: `pkg_chg_o` is high for exactly one cycle, in the first cycle that shows a new package value. It is low in every cycle where the value is unchanged.
- R9: During and straight after reset, every core output and the package output are 0, and `pkg_chg_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| c1e_en_i | input | 1 | Honours extended-halt requests when high |
| perm_i | input | 1 | Platform permission for package low-power entry |
| thr_req_i | input | N_CORES*TPC*3 | Per-thread idle request codes; thread j of core k sits in slot k*TPC+j |
| core_state_o | output | N_CORES*3 | Resolved state of each core; core k sits in slot k |
| pkg_state_o | output | 3 | Resolved package state |
| pkg_chg_o | output | 1 | One-cycle pulse on each package state change |

## Verification
Two events can fall in the same cycle: permission is withdrawn, and the cores deepen or a core wakes. Both feed the same package register, so the bench must show that the permission gate always wins. The bench provokes this by toggling `perm_i` every cycle while all cores sit in off, and by random runs that change permission and thread requests together. A behavioural reference model predicts each core state, the package state and the change pulse for every clock, and the bench compares all of them at each falling edge. This shows that a withdrawn permission forces run, and that the change pulse follows every resulting flip exactly once.

// File: rtl/idle_res_pkg.sv
package idle_res_pkg;
   localparam int unsigned CS_W = 3;

   typedef enum logic [CS_W-1:0] {
      CS_RUN      = 3'd0,
      CS_HALT     = 3'd1,
      CS_HALT_EXT = 3'd2,
      CS_SLEEP    = 3'd3,
      CS_OFF      = 3'd4
   } cstate_e;

   localparam logic [CS_W-1:0] CS_DEEPEST = 3'd4;

   // Shallower of two states: lower code wins.
   function automatic logic [CS_W-1:0] cs_shallower(input logic [CS_W-1:0] a,
                                                     input logic [CS_W-1:0] b);
      return (a < b) ? a : b;
   endfunction
endpackage

// File: rtl/idle_req_norm.sv
module idle_req_norm
   import idle_res_pkg::*;
#(
   parameter bit EXT_SUPPORT = 1'b1
) (
   input  logic [CS_W-1:0] req_i,
   input  logic            ext_en_i,
   output logic [CS_W-1:0] st_o
);
   logic [CS_W-1:0] legal;

   // Codes above the deepest defined state are treated as run.
   assign legal = (req_i > CS_DEEPEST) ? CS_RUN : req_i;

   generate
      if (EXT_SUPPORT) begin : g_ext
         assign st_o = (legal == CS_HALT_EXT && !ext_en_i) ? CS_HALT : legal;
      end else begin : g_noext
         logic unused_ext_en;
         assign unused_ext_en = ext_en_i;
         assign st_o = (legal == CS_HALT_EXT) ? CS_HALT : legal;
      end
   endgenerate
endmodule

// File: rtl/idle_min_reduce.sv
module idle_min_reduce
   import idle_res_pkg::*;
#(
   parameter int unsigned N_IN = 2
) (
   input  logic [N_IN*CS_W-1:0] vec_i,
   output logic [CS_W-1:0]      min_o
);
   initial begin
      if (N_IN < 1) $error("idle_min_reduce: N_IN must be at least 1");
   end

   always_comb begin
      min_o = vec_i[CS_W-1:0];
      for (int i = 1; i < int'(N_IN); i++) begin
         min_o = cs_shallower(min_o, vec_i[i*CS_W +: CS_W]);
      end
   end
endmodule

// File: rtl/idle_core_stage.sv
module idle_core_stage
   import idle_res_pkg::*;
#(
   parameter int unsigned TPC         = 2,
   parameter bit          EXT_SUPPORT = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ext_en_i,
   input  logic [TPC*CS_W-1:0] thr_req_i,
   output logic [CS_W-1:0]     core_st_o
);
   logic [TPC*CS_W-1:0] norm_vec;
   logic [CS_W-1:0]     merged;
   logic [CS_W-1:0]     core_q;

   generate
      for (genvar t = 0; t < int'(TPC); t++) begin : g_thr
         idle_req_norm #(.EXT_SUPPORT(EXT_SUPPORT)) u_norm (
            .req_i    (thr_req_i[t*CS_W +: CS_W]),
            .ext_en_i (ext_en_i),
            .st_o     (norm_vec[t*CS_W +: CS_W])
         );
      end
   endgenerate

   idle_min_reduce #(.N_IN(TPC)) u_min (
      .vec_i (norm_vec),
      .min_o (merged)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) core_q <= CS_RUN;
      else        core_q <= merged;
   end

   assign core_st_o = core_q;
endmodule

// File: rtl/idle_pkg_stage.sv
module idle_pkg_stage
   import idle_res_pkg::*;
#(
   parameter int unsigned N_CORES = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    perm_i,
   input  logic [N_CORES*CS_W-1:0] core_vec_i,
   output logic [CS_W-1:0]         pkg_st_o,
   output logic                    pkg_chg_o
);
   logic [CS_W-1:0] shallow;
   logic [CS_W-1:0] pkg_nxt;
   logic [CS_W-1:0] pkg_q;
   logic            chg_q;

   idle_min_reduce #(.N_IN(N_CORES)) u_min (
      .vec_i (core_vec_i),
      .min_o (shallow)
   );

   // Run and plain halt in any core pin the package to run; so does a
   // missing platform grant.
   always_comb begin
      pkg_nxt = CS_RUN;
      if (perm_i && shallow >= CS_HALT_EXT) pkg_nxt = shallow;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pkg_q <= CS_RUN;
         chg_q <= 1'b0;
      end else begin
         pkg_q <= pkg_nxt;
         chg_q <= (pkg_nxt != pkg_q);
      end
   end

   assign pkg_st_o  = pkg_q;
   assign pkg_chg_o = chg_q;
endmodule

// File: rtl/idle_state_resolver.sv
module idle_state_resolver
   import idle_res_pkg::*;
#(
   parameter int unsigned N_CORES     = 4,
   parameter int unsigned TPC         = 2,
   parameter bit          EXT_SUPPORT = 1'b1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        c1e_en_i,
   input  logic                        perm_i,
   input  logic [N_CORES*TPC*CS_W-1:0] thr_req_i,
   output logic [N_CORES*CS_W-1:0]     core_state_o,
   output logic [CS_W-1:0]             pkg_state_o,
   output logic                        pkg_chg_o
);
   localparam int unsigned CORE_SLICE = TPC * CS_W;

   initial begin
      if (N_CORES < 1 || N_CORES > 64) $error("idle_state_resolver: N_CORES out of range");
      if (TPC < 1 || TPC > 16)         $error("idle_state_resolver: TPC out of range");
   end

   logic [N_CORES*CS_W-1:0] core_vec;

   generate
      for (genvar k = 0; k < int'(N_CORES); k++) begin : g_core
         idle_core_stage #(.TPC(TPC), .EXT_SUPPORT(EXT_SUPPORT)) u_core (
            .clk       (clk),
            .rst_n     (rst_n),
            .ext_en_i  (c1e_en_i),
            .thr_req_i (thr_req_i[k*CORE_SLICE +: CORE_SLICE]),
            .core_st_o (core_vec[k*CS_W +: CS_W])
         );
      end
   endgenerate

   idle_pkg_stage #(.N_CORES(N_CORES)) u_pkg (
      .clk        (clk),
      .rst_n      (rst_n),
      .perm_i     (perm_i),
      .core_vec_i (core_vec),
      .pkg_st_o   (pkg_state_o),
      .pkg_chg_o  (pkg_chg_o)
   );

   assign core_state_o = core_vec;
endmodule

// File: rtl/idle_state_resolver_chk.sv
module idle_state_resolver_chk #(
   parameter int unsigned N_CORES = 4,
   parameter int unsigned TPC     = 2
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     c1e_en_i,
   input logic                     perm_i,
   input logic [N_CORES*TPC*3-1:0] thr_req_i,
   input logic [N_CORES*3-1:0]     core_state_o,
   input logic [2:0]               pkg_state_o,
   input logic                     pkg_chg_o
);
   logic             any_shallow;
   logic             all_off;
   logic             any_ext;
   logic [2:0]       core_min;
   logic [N_CORES-1:0] thr_run;

   always_comb begin
      any_shallow = 1'b0;
      all_off     = 1'b1;
      any_ext     = 1'b0;
      core_min    = 3'd7;
      for (int k = 0; k < int'(N_CORES); k++) begin
         if (core_state_o[k*3 +: 3] < 3'd2)  any_shallow = 1'b1;
         if (core_state_o[k*3 +: 3] != 3'd4) all_off     = 1'b0;
         if (core_state_o[k*3 +: 3] == 3'd2) any_ext     = 1'b1;
         if (core_state_o[k*3 +: 3] < core_min) core_min = core_state_o[k*3 +: 3];
      end
   end

   always_comb begin
      thr_run = '0;
      for (int k = 0; k < int'(N_CORES); k++) begin
         for (int t = 0; t < int'(TPC); t++) begin
            if (thr_req_i[(k*TPC+t)*3 +: 3] == 3'd0) thr_run[k] = 1'b1;
         end
      end
   end

   AST_PKG_LEGAL: assert property (@(posedge clk) disable iff (!rst_n) pkg_state_o <= 3'd4); // R1
   AST_PERM_GATE: assert property (@(posedge clk) disable iff (!rst_n) !perm_i |=> pkg_state_o == 3'd0); // R6
   AST_SHALLOW_CORE: assert property (@(posedge clk) disable iff (!rst_n) any_shallow |=> pkg_state_o == 3'd0); // R5
   AST_OFF_NEEDS_ALL: assert property (@(posedge clk) disable iff (!rst_n) pkg_state_o == 3'd4 |-> $past(all_off && perm_i)); // R7
   AST_PKG_TRACKS_MIN: assert property (@(posedge clk) disable iff (!rst_n) pkg_state_o != 3'd0 |-> pkg_state_o == $past(core_min)); // R4
   AST_NO_EXT_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n) !c1e_en_i |=> !any_ext); // R3
   AST_CHG_ON_MOVE: assert property (@(posedge clk) disable iff (!rst_n) pkg_state_o != $past(pkg_state_o) |-> pkg_chg_o); // R8
   AST_CHG_ONLY_MOVE: assert property (@(posedge clk) disable iff (!rst_n) pkg_chg_o |-> pkg_state_o != $past(pkg_state_o)); // R8

   generate
      for (genvar k = 0; k < int'(N_CORES); k++) begin : g_core
         AST_THREAD_RUN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) thr_run[k] |=> core_state_o[k*3 +: 3] == 3'd0); // R2
      end
   endgenerate
endmodule

bind idle_state_resolver idle_state_resolver_chk #(.N_CORES(N_CORES), .TPC(TPC)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .c1e_en_i     (c1e_en_i),
   .perm_i       (perm_i),
   .thr_req_i    (thr_req_i),
   .core_state_o (core_state_o),
   .pkg_state_o  (pkg_state_o),
   .pkg_chg_o    (pkg_chg_o)
);

// File: tb/idle_state_resolver_test.sv
module idle_state_resolver_test;
   localparam int NC = 4;
   localparam int TP = 2;
   localparam int NT = NC * TP;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            c1e_en_i = 1'b1;
   logic            perm_i = 1'b0;
   logic [NT*3-1:0] thr_req_i = '0;
   logic [NC*3-1:0] core_state_o;
   logic [2:0]      pkg_state_o;
   logic            pkg_chg_o;

   int    checks = 0;
   int    failures = 0;
   int    cyc = 0;
   bit    done = 1'b0;
   string tag = "R9";

   int exp_core [NC];
   int exp_pkg = 0;
   bit exp_chg = 1'b0;

   always #2 clk = ~clk;

   idle_state_resolver #(.N_CORES(NC), .TPC(TP)) uut (
      .clk          (clk),
      .rst_n        (rst_n),
      .c1e_en_i     (c1e_en_i),
      .perm_i       (perm_i),
      .thr_req_i    (thr_req_i),
      .core_state_o (core_state_o),
      .pkg_state_o  (pkg_state_o),
      .pkg_chg_o    (pkg_chg_o)
   );

   // Requirement-level meaning of one thread code (R1, R3).
   function automatic int norm(input int code, input bit en);
      if (code > 4) return 0;
      if (code == 2 && !en) return 1;
      return code;
   endfunction

   // Reference model, advanced once per rising edge.
   always @(posedge clk) begin
      int mn;
      int np;
      int m;
      if (!rst_n) begin
         for (int k = 0; k < NC; k++) exp_core[k] = 0;
         exp_pkg = 0;
         exp_chg = 1'b0;
      end else begin
         mn = 7;
         for (int k = 0; k < NC; k++) if (exp_core[k] < mn) mn = exp_core[k];
         np = (perm_i && mn >= 2) ? mn : 0;
         exp_chg = (np != exp_pkg);
         exp_pkg = np;
         for (int k = 0; k < NC; k++) begin
            m = 7;
            for (int t = 0; t < TP; t++) begin
               if (norm(int'(thr_req_i[(k*TP+t)*3 +: 3]), c1e_en_i) < m)
                  m = norm(int'(thr_req_i[(k*TP+t)*3 +: 3]), c1e_en_i);
            end
            exp_core[k] = m;
         end
      end
   end

   task automatic check_eq(input int act, input int exp, input string what);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (!done) begin
         for (int k = 0; k < NC; k++)
            check_eq(int'(core_state_o[k*3 +: 3]), exp_core[k], $sformatf("core%0d", k));
         check_eq(int'(pkg_state_o), exp_pkg, "package");
         check_eq(int'(pkg_chg_o), int'(exp_chg), "change pulse");
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000 && !done) begin
         done = 1'b1;
         failures++;
         checks++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 100000);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic hold(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic set_all(input logic [2:0] c);
      for (int i = 0; i < NT; i++) thr_req_i[i*3 +: 3] = c;
   endtask

   initial begin
      // R9: reset state
      tag = "R9";
      hold(3);
      rst_n = 1'b1;
      hold(2);

      // R2: core merge of mixed thread requests
      tag = "R2";
      perm_i = 1'b1;
      set_all(3'd1);
      hold(3);
      for (int k = 0; k < NC; k++) begin
         thr_req_i[(k*TP)*3 +: 3]   = 3'd4;
         thr_req_i[(k*TP+1)*3 +: 3] = 3'(k + 1);
      end
      hold(4);

      // R7: all cores off, then one core in sleep
      tag = "R7";
      set_all(3'd4);
      hold(4);
      thr_req_i[3*3 +: 3] = 3'd3;
      hold(4);

      // R5: one thread running pins its core and the package
      tag = "R5";
      set_all(3'd4);
      thr_req_i[5*3 +: 3] = 3'd0;
      hold(4);
      thr_req_i[5*3 +: 3] = 3'd1;
      hold(3);

      // R6: permission withdrawn while all cores are off
      tag = "R6";
      set_all(3'd4);
      hold(3);
      perm_i = 1'b0;
      hold(3);
      perm_i = 1'b1;
      hold(3);
      perm_i = 1'b0;
      hold(2);
      perm_i = 1'b1;

      // R4: extended halt honoured; R3: folded when disabled
      tag = "R4";
      set_all(3'd2);
      hold(4);
      tag = "R3";
      c1e_en_i = 1'b0;
      hold(4);
      c1e_en_i = 1'b1;
      hold(3);

      // R1: illegal codes count as run
      tag = "R1";
      set_all(3'd7);
      hold(3);
      set_all(3'd4);
      thr_req_i[0 +: 3] = 3'd5;
      thr_req_i[7*3 +: 3] = 3'd6;
      hold(4);

      // R8: permission toggled every cycle with all cores off
      tag = "R8";
      set_all(3'd4);
      hold(3);
      for (int i = 0; i < 12; i++) begin
         perm_i = ~perm_i;
         hold(1);
      end
      perm_i = 1'b1;
      hold(3);

      // R4: random mix of requests, permission and enable together
      tag = "R4";
      for (int i = 0; i < 600; i++) begin
         for (int j = 0; j < NT; j++) begin
            int r;
            r = int'($urandom % 20);
            if (r < 11)      thr_req_i[j*3 +: 3] = 3'd4;
            else if (r < 15) thr_req_i[j*3 +: 3] = 3'd3;
            else if (r < 17) thr_req_i[j*3 +: 3] = 3'd2;
            else             thr_req_i[j*3 +: 3] = 3'($urandom % 8);
         end
         perm_i   = ($urandom % 6) != 0;
         c1e_en_i = ($urandom % 2) != 0;
         hold(1 + int'($urandom % 3));
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule